// File: doc/BRIEF.md
# Page Table Address Translator

The block maps 16-bit virtual addresses onto 16-bit physical addresses with a page table held in registers inside the block. Pages are 1 KB. The upper six address bits pick one of 64 table entries, and the ten low bits carry straight through as the page offset. The operating-system side fills the table through a configuration write port. Each write sets an entry's valid flag and frame number and returns that entry's usage bits to zero.

A requester sends an address and a read/write flag. One cycle later the block answers with a response strobe, and either the physical address or a page fault. Every access that hits marks its entry as referenced, and a write also marks it dirty. A programmable sweep timer clears all reference marks together. A priority finder reports a replacement candidate at all times: the lowest-numbered mapped page that has not been referenced since the last sweep, together with that page's dirty state.

Top module: `pgxlat_top`

## Requirements
- R1: On a hit, `rsp_paddr` is the entry's 6-bit frame number in bits 15:10, with virtual address bits 9:0 copied unchanged into bits 9:0.
- R2: Virtual address bits 15:10 form the page number. It selects one of 64 entries, with entry k covering addresses k*1024 to k*1024+1023.
- R3: A configuration write with `cfg_we`=1 loads the valid flag and the frame of entry `cfg_vpn` at the clock edge and clears that entry's reference and dirty marks. Configuration takes precedence over an access to the same entry in the same cycle.
- R4: A request with `req_valid`=1 at an edge produces `rsp_valid`=1 for exactly the following cycle. With no request, `rsp_valid` stays 0.
- R5: An access to an entry whose valid flag is 0 responds with `rsp_fault`=1 and `rsp_paddr`=0.
- R6: An access that hits sets the reference mark of the selected entry.
- R7: With `clr_interval`=N>0, the reference marks of all entries are cleared at every N-th clock edge, counted from the cycle N was applied while the counter stood at zero. N=0 disables clearing.
- R8: A write access that hits sets the entry's dirty mark. Reads and sweeps leave dirty marks unchanged.
- R9: `victim_found`=1 and `victim_vpn` gives the lowest-numbered entry that is valid with its reference mark clear. If no entry qualifies, `victim_found`=0 and `victim_vpn`=0.
- R10: `victim_dirty` equals the dirty mark of the reported victim, and is 0 when no victim exists.
- R11: When a hit and a sweep fall on the same edge, the hit entry's reference mark ends up set.
- R12: Reset invalidates every entry, clears all marks and the sweep counter, and drives `rsp_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table configuration write strobe |
| cfg_vpn | input | 6 | Entry written by the configuration port |
| cfg_valid | input | 1 | Valid flag to load |
| cfg_frame | input | 6 | Frame number to load |
| clr_interval | input | 16 | Sweep period in cycles, 0 turns sweeping off |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 16 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_fault | output | 1 | Page fault indication |
| rsp_paddr | output | 16 | Physical address, zero on a fault |
| victim_found | output | 1 | A replacement candidate exists |
| victim_vpn | output | 6 | Page number of the candidate |
| victim_dirty | output | 1 | Dirty mark of the candidate |

## Verification
The assertions check the following on every cycle: the response follows a request by exactly one cycle, a fault carries a zero address, the offset passes through, a hit leaves the reference mark set (and the dirty mark on writes), a sweep leaves at most one reference mark standing, and the candidate is always valid and unreferenced. Other behaviour needs the bench's scenarios to show it. That includes the exact frame placed into the address for each mapping, the cycle on which a sweep lands, the precedence of a hit over a same-edge sweep, the lowest-index choice among several candidates, and the clearing of the marks by a reconfiguration.

// File: rtl/pgxlat_pkg.sv
package pgxlat_pkg;
  localparam int PGX_VA_W  = 16;
  localparam int PGX_PA_W  = 16;
  localparam int PGX_OFF_W = 10;
  localparam int PGX_CNT_W = 16;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/pgxlat_sweep.sv
module pgxlat_sweep #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] interval,
  output logic             clr_pulse
);
  logic [CNT_W-1:0] cnt_q;
  logic             enabled;

  assign enabled   = (interval != '0);
  assign clr_pulse = enabled && (cnt_q >= interval - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!enabled)   cnt_q <= '0;
    else if (clr_pulse)  cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (enabled && $stable(interval)) |-> (cnt_q < interval)); // R7
endmodule

// File: rtl/pgxlat_table.sv
module pgxlat_table #(
  parameter int VPN_W   = 6,
  parameter int FRAME_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [VPN_W-1:0]   cfg_vpn,
  input  logic               cfg_valid,
  input  logic [FRAME_W-1:0] cfg_frame,
  input  logic               clr_pulse,
  input  logic               acc_en,
  input  logic [VPN_W-1:0]   acc_vpn,
  input  logic               acc_write,
  output logic               lk_valid,
  output logic [FRAME_W-1:0] lk_frame,
  output logic [(1<<VPN_W)-1:0] valid_vec,
  output logic [(1<<VPN_W)-1:0] ref_vec,
  output logic [(1<<VPN_W)-1:0] dirty_vec
);
  localparam int ENTRIES = 1 << VPN_W;

  logic [FRAME_W-1:0] frame_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q, ref_q, dirty_q;

  // named internal events
  logic hit;
  logic touch;       // hit not overridden by a same-entry configuration write
  logic cfg_clash;

  assign lk_valid  = valid_q[acc_vpn];
  assign lk_frame  = frame_q[acc_vpn];
  assign hit       = acc_en && lk_valid;
  assign cfg_clash = cfg_we && (cfg_vpn == acc_vpn);
  assign touch     = hit && !cfg_clash;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic sel_cfg, sel_acc;
    assign sel_cfg = cfg_we && (cfg_vpn == VPN_W'(e));
    assign sel_acc = hit && (acc_vpn == VPN_W'(e));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[e] <= 1'b0;
        ref_q[e]   <= 1'b0;
        dirty_q[e] <= 1'b0;
        frame_q[e] <= '0;
      end else if (sel_cfg) begin
        valid_q[e] <= cfg_valid;
        frame_q[e] <= cfg_frame;
        ref_q[e]   <= 1'b0;
        dirty_q[e] <= 1'b0;
      end else begin
        if (sel_acc)        ref_q[e] <= 1'b1;   // reference beats sweep
        else if (clr_pulse) ref_q[e] <= 1'b0;
        if (sel_acc && acc_write) dirty_q[e] <= 1'b1;
      end
    end
  end

  assign valid_vec = valid_q;
  assign ref_vec   = ref_q;
  assign dirty_vec = dirty_q;

  AST_REF_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    touch |=> ref_q[$past(acc_vpn)]); // R6

  AST_DIRTY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (touch && acc_write) |=> dirty_q[$past(acc_vpn)]); // R8

  AST_SWEEP_LEAVES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> ($countones(ref_q) <= 1)); // R7

  AST_CFG_CLEARS_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (!ref_q[$past(cfg_vpn)] && !dirty_q[$past(cfg_vpn)])); // R3
endmodule

// File: rtl/pgxlat_victim.sv
module pgxlat_victim #(
  parameter int VPN_W = 6
) (
  input  logic [(1<<VPN_W)-1:0] valid_vec,
  input  logic [(1<<VPN_W)-1:0] ref_vec,
  input  logic [(1<<VPN_W)-1:0] dirty_vec,
  output logic                  found,
  output logic [VPN_W-1:0]      vpn,
  output logic                  dirty
);
  localparam int ENTRIES = 1 << VPN_W;

  logic [ENTRIES-1:0] eligible;
  assign eligible = valid_vec & ~ref_vec;

  always_comb begin
    found = 1'b0;
    vpn   = '0;
    dirty = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        found = 1'b1;
        vpn   = VPN_W'(i);
        dirty = dirty_vec[i];
      end
    end
  end
endmodule

// File: rtl/pgxlat_top.sv
module pgxlat_top
  import pgxlat_pkg::*;
#(
  parameter int VA_W  = PGX_VA_W,
  parameter int PA_W  = PGX_PA_W,
  parameter int OFF_W = PGX_OFF_W,
  parameter int CNT_W = PGX_CNT_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [VA_W-OFF_W-1:0] cfg_vpn,
  input  logic                  cfg_valid,
  input  logic [PA_W-OFF_W-1:0] cfg_frame,
  input  logic [CNT_W-1:0]      clr_interval,
  input  logic                  req_valid,
  input  logic [VA_W-1:0]       req_vaddr,
  input  logic                  req_write,
  output logic                  rsp_valid,
  output logic                  rsp_fault,
  output logic [PA_W-1:0]       rsp_paddr,
  output logic                  victim_found,
  output logic [VA_W-OFF_W-1:0] victim_vpn,
  output logic                  victim_dirty
);
  localparam int VPN_W   = VA_W - OFF_W;
  localparam int FRAME_W = PA_W - OFF_W;
  localparam int ENTRIES = 1 << VPN_W;

  function automatic logic [VPN_W-1:0] page_of(input logic [VA_W-1:0] va);
    return va[VA_W-1:OFF_W];
  endfunction

  function automatic logic [OFF_W-1:0] offset_of(input logic [VA_W-1:0] va);
    return va[OFF_W-1:0];
  endfunction

  function automatic logic [PA_W-1:0] join_pa(input logic [FRAME_W-1:0] fr,
                                               input logic [OFF_W-1:0] off);
    return {fr, off};
  endfunction

  logic               clr_pulse;
  logic               lk_valid;
  logic [FRAME_W-1:0] lk_frame;
  logic [ENTRIES-1:0] valid_vec, ref_vec, dirty_vec;
  acc_kind_e          acc_kind;

  assign acc_kind = !req_valid ? ACC_NONE : (req_write ? ACC_WRITE : ACC_READ);

  pgxlat_sweep #(.CNT_W(CNT_W)) u_sweep (
    .clk(clk), .rst_n(rst_n), .interval(clr_interval), .clr_pulse(clr_pulse)
  );

  pgxlat_table #(.VPN_W(VPN_W), .FRAME_W(FRAME_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_vpn(cfg_vpn), .cfg_valid(cfg_valid), .cfg_frame(cfg_frame),
    .clr_pulse(clr_pulse),
    .acc_en(acc_kind != ACC_NONE), .acc_vpn(page_of(req_vaddr)),
    .acc_write(acc_kind == ACC_WRITE),
    .lk_valid(lk_valid), .lk_frame(lk_frame),
    .valid_vec(valid_vec), .ref_vec(ref_vec), .dirty_vec(dirty_vec)
  );

  pgxlat_victim #(.VPN_W(VPN_W)) u_victim (
    .valid_vec(valid_vec), .ref_vec(ref_vec), .dirty_vec(dirty_vec),
    .found(victim_found), .vpn(victim_vpn), .dirty(victim_dirty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_fault <= !lk_valid;
        rsp_paddr <= lk_valid ? join_pa(lk_frame, offset_of(req_vaddr)) : '0;
      end
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R4

  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R4

  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0)); // R5

  AST_OFFSET_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]))); // R1

  AST_VICTIM_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    victim_found |-> (valid_vec[victim_vpn] && !ref_vec[victim_vpn])); // R9

  AST_VICTIM_DIRTY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !victim_found |-> (!victim_dirty && victim_vpn == '0)); // R10
endmodule

// File: tb/tb_pgxlat_top.sv
`timescale 1ns/1ps
module tb_pgxlat_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_valid;
  logic [5:0]  cfg_vpn, cfg_frame;
  logic [15:0] clr_interval;
  logic        req_valid, req_write;
  logic [15:0] req_vaddr;
  logic        rsp_valid, rsp_fault;
  logic [15:0] rsp_paddr;
  logic        victim_found, victim_dirty;
  logic [5:0]  victim_vpn;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pgxlat_top dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_vpn(cfg_vpn), .cfg_valid(cfg_valid), .cfg_frame(cfg_frame),
    .clr_interval(clr_interval),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
    .victim_found(victim_found), .victim_vpn(victim_vpn), .victim_dirty(victim_dirty)
  );

  // {vaddr[15:0], write, expected fault, expected paddr[15:0]}
  // mapping loaded: entry k valid unless k%3==2, frame (5k+9)%64
  localparam logic [33:0] VEC [8] = '{
    {16'h041C, 1'b0, 1'b0, 16'h381C},
    {16'h08AD, 1'b0, 1'b1, 16'h0000},
    {16'h157B, 1'b0, 1'b1, 16'h0000},
    {16'h0000, 1'b0, 1'b0, 16'h2400},
    {16'hFFFF, 1'b0, 1'b0, 16'h13FF},
    {16'hF800, 1'b1, 1'b1, 16'h0000},
    {16'h0DFF, 1'b1, 1'b0, 16'h61FF},
    {16'h7A05, 1'b0, 1'b0, 16'h7E05}
  };

  function automatic logic [5:0] map_frame(input int k);
    return 6'((5 * k + 9) % 64);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input int k, input bit v, input logic [5:0] fr);
    @(negedge clk);
    cfg_we = 1'b1; cfg_vpn = 6'(k); cfg_valid = v; cfg_frame = fr;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // request at one edge, response sampled at the following negedge
  task automatic do_req(input logic [15:0] va, input bit wr);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic check_victim(input string tag, input bit f, input int v, input bit d);
    check(victim_found == f && victim_vpn == 6'(v) && victim_dirty == d, tag,
          {victim_found, victim_dirty, victim_vpn}, {f, d, 6'(v)});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 0; cfg_vpn = 0; cfg_valid = 0; cfg_frame = 0;
    clr_interval = 0; req_valid = 0; req_vaddr = 0; req_write = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    check(rsp_valid == 0, "R12 rsp_valid after reset", rsp_valid, 0);
    check_victim("R12 no victim after reset", 0, 0, 0);

    // R3: load the table
    for (int k = 0; k < 64; k++) cfg_write(k, (k % 3) != 2, map_frame(k));
    check_victim("R3 R9 lowest unreferenced after config", 1, 0, 0);

    // R1 R2 R5 R6 R8: vector walk
    for (int i = 0; i < 8; i++) begin
      do_req(VEC[i][33:18], VEC[i][17]);
      check(rsp_valid == 1, $sformatf("R4 rsp_valid vec %0d", i), rsp_valid, 1);
      check(rsp_fault == VEC[i][16], $sformatf("R5 fault vec %0d", i), rsp_fault, VEC[i][16]);
      check(rsp_paddr == VEC[i][15:0], $sformatf("R1 R2 paddr vec %0d", i), rsp_paddr, VEC[i][15:0]);
    end
    // refs now on 0,1,3,30,63 -> candidate 4 (R6 R9)
    check_victim("R6 R9 victim skips referenced", 1, 4, 0);
    @(negedge clk);
    check(rsp_valid == 0, "R4 no response without request", rsp_valid, 0);

    // R7: sweep lands on the 4th edge after N=4 applied
    clr_interval = 16'd4;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_victim("R7 no sweep before period", 1, 4, 0);
    @(posedge clk); @(negedge clk);
    check_victim("R7 sweep at period", 1, 0, 0);
    clr_interval = 16'd0;

    // R8 R10: entry 3 was written; dirty survives the sweep
    cfg_write(0, 0, 6'd0);
    cfg_write(1, 0, 6'd0);
    check_victim("R8 R10 dirty victim", 1, 3, 1);
    // R3: reconfiguration clears dirty
    cfg_write(3, 1, map_frame(3));
    check_victim("R3 reconfig clears dirty", 1, 3, 0);

    // R11: sweep every cycle, a hit still leaves its mark
    clr_interval = 16'd1;
    do_req(16'h0C00, 1'b0);
    check(rsp_paddr == 16'h6000, "R1 paddr entry 3", rsp_paddr, 16'h6000);
    check_victim("R11 hit beats same-edge sweep", 1, 4, 0);
    @(posedge clk); @(negedge clk);
    check_victim("R7 R11 next sweep clears", 1, 3, 0);
    clr_interval = 16'd0;

    // R12: reset mid-run, then R9 with no eligible entry
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check(rsp_valid == 0, "R12 rsp_valid low after reset", rsp_valid, 0);
    check_victim("R12 table empty", 0, 0, 0);
    do_req(16'h0400, 1'b0);
    check(rsp_fault == 1 && rsp_paddr == 0, "R12 R5 fault after reset",
          {rsp_fault, rsp_paddr}, {1'b1, 16'h0});
    cfg_write(5, 1, 6'd17);
    check_victim("R9 single candidate", 1, 5, 0);
    do_req(16'h1401, 1'b1);
    check(rsp_paddr == 16'h4401, "R1 R2 paddr entry 5", rsp_paddr, 16'h4401);
    check_victim("R9 R10 none eligible", 0, 0, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule